// File: doc/BRIEF.md
# Four-Channel DMA Channel Programming Register File

This block is the register file that a CPU programs before a byte-wide DMA transfer engine runs. It sits on an 8-bit I/O bus with an address, write data, read data and one-cycle read and write strobes. For each of four channels it keeps a 16-bit buffer offset, a 16-bit block count (length minus one), an 8-bit page byte and a mode word. It also keeps one mask bit and one request bit per channel, a command byte, and terminal-count flags.

The 16-bit registers are reached through a single 8-bit port per register. A shared byte pointer selects the low byte first and the high byte second. Each CPU write fills both a base copy and a working copy of the register. Reads return the working copy. The transfer engine updates the working copies through a side port and can restore them from the base copies for auto-initialization. The mode, mask, page and working values are driven out to the engine continuously.

Top module: `dma_regfile`

## Requirements
- R1: After reset every channel is masked (ch_mask = 1111b). All mode fields, offsets, counts, pages, requests, terminal-count flags and the command byte are zero. The byte pointer selects the low byte.
- R2: A write to a channel's offset or count port stores the data into the byte chosen by the pointer, low byte (7:0) first and high byte (15:8) second. Each write loads the base copy and the working copy together.
- R3: A read of an offset or count port returns the selected byte of the working copy. Every read or write of these ports toggles the pointer. A write of any data to 0Ch returns the pointer to the low byte.
- R4: Ports 00h, 02h, 04h and 06h are the offsets of channels 0 to 3. Ports 01h, 03h, 05h and 07h are their counts.
- R5: The page bytes of channels 0, 1, 2 and 3 are written at 87h, 83h, 81h and 82h. A read of any write-only port (the four page ports and 09h to 0Fh) returns 00h and leaves the pointer unchanged.
- R6: A write to 0Bh sets the mode of the channel named by data bits 1:0. Bits 7:6 give the transfer style (00 demand, 01 single, 10 block, 11 cascade). Bit 5 set means decrementing address. Bit 4 set means auto-initialize. Bits 3:2 give the direction (00 verify, 01 to memory, 10 from memory).
- R7: A write to 0Ah sets the mask of the channel named by bits 1:0 to data bit 2. No other write changes a mask bit.
- R8: A write to 0Dh sets all masks and clears the modes, requests, command, terminal-count flags and pointer. Offsets, counts and pages are kept.
- R9: A write to 0Eh clears all masks. A write to 0Fh loads the four masks from data bits 3:0.
- R10: An engine update (eng_we) loads the working offset and count of channel eng_ch. An engine reload (eng_reload, which wins over eng_we) copies that channel's base offset and count into the working copies.
- R11: An engine update whose count is FFFFh sets that channel's terminal-count flag. A read of 08h returns requests in bits 7:4 and flags in bits 3:0, then clears the flags.
- R12: A write to 09h sets the request bit of the channel named by bits 1:0 to data bit 2.
- R13: A write to 08h stores the whole data byte as the command byte on cmd_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | I/O port address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| eng_we | input | 1 | Engine update of working offset and count |
| eng_reload | input | 1 | Engine request to restore the working copies from the base copies |
| eng_ch | input | 2 | Channel addressed by the engine |
| eng_offset | input | 16 | New working offset |
| eng_count | input | 16 | New working count |
| ch_mask | output | 4 | Mask bit per channel |
| ch_req | output | 4 | Software request bit per channel |
| ch_tc | output | 4 | Terminal-count flag per channel |
| cmd_out | output | 8 | Command byte |
| ch_xfer | output | 8 | Transfer style, 2 bits per channel |
| ch_dec | output | 4 | Address-decrement flag per channel |
| ch_autoinit | output | 4 | Auto-initialize flag per channel |
| ch_kind | output | 8 | Transfer direction, 2 bits per channel |
| ch_page | output | 32 | Page byte, 8 bits per channel |
| ch_offset | output | 64 | Working offset, 16 bits per channel |
| ch_count | output | 64 | Working count, 16 bits per channel |

## Verification
The bench uses the default package values: four channels, 16-bit registers and an 8-bit bus. With these values every channel decode and every page address can be reached. With a full 16-bit count, the all-ones terminal value can be driven through the engine port without a long countdown. Because there are four channels, a single-channel write can be checked against the other three outputs. The pointer parity is followed across long mixed sequences of reads, writes and clear commands.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
    localparam int NUM_CH   = 4;
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int BUS_W    = 8;
    localparam int REG_W    = 16;
    localparam int PAGE_W   = 8;
    localparam int MODE_W   = 6;

    localparam logic [BUS_W-1:0] A_CMD     = 8'h08;
    localparam logic [BUS_W-1:0] A_REQ     = 8'h09;
    localparam logic [BUS_W-1:0] A_SMASK   = 8'h0A;
    localparam logic [BUS_W-1:0] A_MODE    = 8'h0B;
    localparam logic [BUS_W-1:0] A_CLRPTR  = 8'h0C;
    localparam logic [BUS_W-1:0] A_MRESET  = 8'h0D;
    localparam logic [BUS_W-1:0] A_MENABLE = 8'h0E;
    localparam logic [BUS_W-1:0] A_MMASK   = 8'h0F;

    // Field order matches data bits 7:2 of a mode write.
    typedef struct packed {
        logic [1:0] xfer;
        logic       dec;
        logic       autoinit;
        logic [1:0] kind;
    } mode_t;

    typedef struct packed {
        logic            hit_offset;
        logic            hit_count;
        logic            hit_page;
        logic [CH_W-1:0] ch;
        logic            cmd;
        logic            req;
        logic            smask;
        logic            mode;
        logic            clrptr;
        logic            mreset;
        logic            menable;
        logic            mmask;
        logic            wo;
    } dec_t;
endpackage

// File: rtl/dma_rf_decode.sv
module dma_rf_decode
    import dma_rf_pkg::*;
(
    input  logic [BUS_W-1:0] addr,
    output dec_t             dec
);
    always_comb begin
        dec = '0;
        if (addr[7:3] == 5'b00000) begin
            dec.ch         = addr[CH_W:1];
            dec.hit_offset = ~addr[0];
            dec.hit_count  = addr[0];
        end
        unique case (addr)
            A_CMD:     dec.cmd     = 1'b1;
            A_REQ:     dec.req     = 1'b1;
            A_SMASK:   dec.smask   = 1'b1;
            A_MODE:    dec.mode    = 1'b1;
            A_CLRPTR:  dec.clrptr  = 1'b1;
            A_MRESET:  dec.mreset  = 1'b1;
            A_MENABLE: dec.menable = 1'b1;
            A_MMASK:   dec.mmask   = 1'b1;
            8'h87: begin dec.hit_page = 1'b1; dec.ch = CH_W'(0); end
            8'h83: begin dec.hit_page = 1'b1; dec.ch = CH_W'(1); end
            8'h81: begin dec.hit_page = 1'b1; dec.ch = CH_W'(2); end
            8'h82: begin dec.hit_page = 1'b1; dec.ch = CH_W'(3); end
            default: ;
        endcase
        dec.wo = dec.hit_page | dec.req | dec.smask | dec.mode | dec.clrptr
               | dec.mreset | dec.menable | dec.mmask;
    end
endmodule

// File: rtl/dma_rf_channel.sv
module dma_rf_channel
    import dma_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_off,
    input  logic              wr_cnt,
    input  logic              wr_page,
    input  logic              wr_mode,
    input  logic              clr_mode,
    input  logic              ptr_hi,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              eng_upd,
    input  logic              eng_rld,
    input  logic [REG_W-1:0]  eng_offset,
    input  logic [REG_W-1:0]  eng_count,
    output logic [REG_W-1:0]  cur_off,
    output logic [REG_W-1:0]  cur_cnt,
    output logic [PAGE_W-1:0] page,
    output mode_t             mode
);
    typedef struct packed {
        logic [REG_W-1:0]  base_off;
        logic [REG_W-1:0]  base_cnt;
        logic [REG_W-1:0]  cur_off;
        logic [REG_W-1:0]  cur_cnt;
        logic [PAGE_W-1:0] page;
        mode_t             mode;
    } ch_state_t;

    ch_state_t s_d, s_q;
    int        lane;

    always_comb begin
        s_d  = s_q;
        lane = int'(ptr_hi) * BUS_W;
        // Engine first; a CPU byte write in the same cycle overrides its byte.
        if (eng_rld) begin
            s_d.cur_off = s_q.base_off;
            s_d.cur_cnt = s_q.base_cnt;
        end else if (eng_upd) begin
            s_d.cur_off = eng_offset;
            s_d.cur_cnt = eng_count;
        end
        if (wr_off) begin
            s_d.base_off[lane +: BUS_W] = wdata;
            s_d.cur_off[lane +: BUS_W]  = wdata;
        end
        if (wr_cnt) begin
            s_d.base_cnt[lane +: BUS_W] = wdata;
            s_d.cur_cnt[lane +: BUS_W]  = wdata;
        end
        if (wr_page) s_d.page = wdata;
        if (wr_mode) s_d.mode = mode_t'(wdata[BUS_W-1 -: MODE_W]);
        if (clr_mode) s_d.mode = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur_off = s_q.cur_off;
    assign cur_cnt = s_q.cur_cnt;
    assign page    = s_q.page;
    assign mode    = s_q.mode;
endmodule

// File: rtl/dma_rf_ctrl.sv
module dma_rf_ctrl
    import dma_rf_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc16,
    input  logic             clrptr_wr,
    input  logic             smask_wr,
    input  logic             req_wr,
    input  logic             cmd_wr,
    input  logic             menable_wr,
    input  logic             mmask_wr,
    input  logic             mreset_wr,
    input  logic             status_rd,
    input  logic [BUS_W-1:0] wdata,
    input  logic [NCH-1:0]   tc_set,
    output logic             ptr_hi,
    output logic [NCH-1:0]   mask,
    output logic [NCH-1:0]   req,
    output logic [NCH-1:0]   tc,
    output logic [BUS_W-1:0] cmd
);
    typedef struct packed {
        logic             ptr;
        logic [NCH-1:0]   mask;
        logic [NCH-1:0]   req;
        logic [NCH-1:0]   tc;
        logic [BUS_W-1:0] cmd;
    } ctl_state_t;

    ctl_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (acc16)     s_d.ptr = ~s_q.ptr;
        if (clrptr_wr) s_d.ptr = 1'b0;
        if (smask_wr)  s_d.mask[wdata[CH_W-1:0]] = wdata[2];
        if (menable_wr) s_d.mask = '0;
        if (mmask_wr)  s_d.mask = wdata[NCH-1:0];
        if (req_wr)    s_d.req[wdata[CH_W-1:0]] = wdata[2];
        if (cmd_wr)    s_d.cmd = wdata;
        if (status_rd) s_d.tc = '0;
        s_d.tc = s_d.tc | tc_set;
        if (mreset_wr) begin
            s_d.ptr  = 1'b0;
            s_d.mask = '1;
            s_d.req  = '0;
            s_d.tc   = '0;
            s_d.cmd  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mask <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ptr_hi = s_q.ptr;
    assign mask   = s_q.mask;
    assign req    = s_q.req;
    assign tc     = s_q.tc;
    assign cmd    = s_q.cmd;
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_rf_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BUS_W-1:0]      bus_addr,
    input  logic [BUS_W-1:0]      bus_wdata,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    output logic [BUS_W-1:0]      bus_rdata,
    input  logic                  eng_we,
    input  logic                  eng_reload,
    input  logic [CH_W-1:0]       eng_ch,
    input  logic [REG_W-1:0]      eng_offset,
    input  logic [REG_W-1:0]      eng_count,
    output logic [NCH-1:0]        ch_mask,
    output logic [NCH-1:0]        ch_req,
    output logic [NCH-1:0]        ch_tc,
    output logic [BUS_W-1:0]      cmd_out,
    output logic [2*NCH-1:0]      ch_xfer,
    output logic [NCH-1:0]        ch_dec,
    output logic [NCH-1:0]        ch_autoinit,
    output logic [2*NCH-1:0]      ch_kind,
    output logic [PAGE_W*NCH-1:0] ch_page,
    output logic [REG_W*NCH-1:0]  ch_offset,
    output logic [REG_W*NCH-1:0]  ch_count
);
    dec_t             dec;
    logic             ptr_hi;
    logic             mreset_wr;
    logic [NCH-1:0]   tc_set;
    logic [REG_W-1:0] off_a [NCH];
    logic [REG_W-1:0] cnt_a [NCH];

    dma_rf_decode u_dec (.addr(bus_addr), .dec(dec));

    assign mreset_wr = bus_wr & dec.mreset;

    dma_rf_ctrl #(.NCH(NCH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc16      ((bus_wr | bus_rd) & (dec.hit_offset | dec.hit_count)),
        .clrptr_wr  (bus_wr & dec.clrptr),
        .smask_wr   (bus_wr & dec.smask),
        .req_wr     (bus_wr & dec.req),
        .cmd_wr     (bus_wr & dec.cmd),
        .menable_wr (bus_wr & dec.menable),
        .mmask_wr   (bus_wr & dec.mmask),
        .mreset_wr  (mreset_wr),
        .status_rd  (bus_rd & dec.cmd),
        .wdata      (bus_wdata),
        .tc_set     (tc_set),
        .ptr_hi     (ptr_hi),
        .mask       (ch_mask),
        .req        (ch_req),
        .tc         (ch_tc),
        .cmd        (cmd_out)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic  here;
        logic  eng_here;
        mode_t md;

        assign here     = bus_wr & (dec.ch == CH_W'(g));
        assign eng_here = eng_ch == CH_W'(g);
        assign tc_set[g] = eng_here & eng_we & ~eng_reload & (&eng_count);

        dma_rf_channel u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_off     (here & dec.hit_offset),
            .wr_cnt     (here & dec.hit_count),
            .wr_page    (here & dec.hit_page),
            .wr_mode    (bus_wr & dec.mode & (bus_wdata[CH_W-1:0] == CH_W'(g))),
            .clr_mode   (mreset_wr),
            .ptr_hi     (ptr_hi),
            .wdata      (bus_wdata),
            .eng_upd    (eng_here & eng_we),
            .eng_rld    (eng_here & eng_reload),
            .eng_offset (eng_offset),
            .eng_count  (eng_count),
            .cur_off    (off_a[g]),
            .cur_cnt    (cnt_a[g]),
            .page       (ch_page[g*PAGE_W +: PAGE_W]),
            .mode       (md)
        );

        assign ch_offset[g*REG_W +: REG_W] = off_a[g];
        assign ch_count[g*REG_W +: REG_W]  = cnt_a[g];
        assign ch_xfer[2*g +: 2]  = md.xfer;
        assign ch_dec[g]          = md.dec;
        assign ch_autoinit[g]     = md.autoinit;
        assign ch_kind[2*g +: 2]  = md.kind;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && !dec.wo) begin
            if (dec.hit_offset)
                bus_rdata = off_a[dec.ch][int'(ptr_hi)*BUS_W +: BUS_W];
            else if (dec.hit_count)
                bus_rdata = cnt_a[dec.ch][int'(ptr_hi)*BUS_W +: BUS_W];
            else if (dec.cmd)
                bus_rdata = BUS_W'({ch_req, ch_tc});
        end
    end
endmodule

// File: rtl/dma_rf_chk.sv
module dma_rf_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  bus_addr,
    input logic [3:0]  mm_data,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [7:0]  bus_rdata,
    input logic        eng_we,
    input logic        eng_reload,
    input logic [1:0]  eng_ch,
    input logic [15:0] eng_offset,
    input logic [15:0] eng_count,
    input logic [3:0]  ch_mask,
    input logic [3:0]  ch_req,
    input logic [3:0]  ch_tc,
    input logic [7:0]  ch_xfer,
    input logic [15:0] off0,
    input logic [15:0] cnt0
);
    logic wo_port;
    logic eng0;
    assign wo_port = bus_addr inside {8'h81, 8'h82, 8'h83, 8'h87, 8'h09, 8'h0A,
                                      8'h0B, 8'h0C, 8'h0D, 8'h0E, 8'h0F};
    assign eng0 = eng_we && !eng_reload && eng_ch == 2'd0;

    assert_wo_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && wo_port) |-> bus_rdata == 8'h00);

    assert_mreset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h0D) |=>
        (ch_mask == 4'hF && ch_xfer == 8'h00 && ch_req == 4'h0 && ch_tc == 4'h0));

    assert_menable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h0E) |=> ch_mask == 4'h0);

    assert_mmask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h0F) |=> ch_mask == $past(mm_data));

    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr inside {8'h0A, 8'h0D, 8'h0E, 8'h0F}) |=> $stable(ch_mask));

    assert_eng_upd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng0 && !(bus_wr && bus_addr inside {8'h00, 8'h01})) |=>
        (off0 == $past(eng_offset) && cnt0 == $past(eng_count)));

    assert_tc_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eng0 && eng_count == 16'hFFFF && !(bus_wr && bus_addr == 8'h0D)) |=> ch_tc[0]);

    assert_off_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_wr && bus_addr == 8'h00) && !((eng_we || eng_reload) && eng_ch == 2'd0))
        |=> $stable(off0));
endmodule

bind dma_regfile dma_rf_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .mm_data    (bus_wdata[3:0]),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_rdata  (bus_rdata),
    .eng_we     (eng_we),
    .eng_reload (eng_reload),
    .eng_ch     (eng_ch),
    .eng_offset (eng_offset),
    .eng_count  (eng_count),
    .ch_mask    (ch_mask),
    .ch_req     (ch_req),
    .ch_tc      (ch_tc),
    .ch_xfer    (ch_xfer),
    .off0       (ch_offset[15:0]),
    .cnt0       (ch_count[15:0])
);

// File: tb/sim_dma_regfile.sv
module sim_dma_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic        eng_we = 1'b0;
    logic        eng_reload = 1'b0;
    logic [1:0]  eng_ch = '0;
    logic [15:0] eng_offset = '0;
    logic [15:0] eng_count = '0;
    logic [3:0]  ch_mask, ch_req, ch_tc, ch_dec, ch_autoinit;
    logic [7:0]  cmd_out, ch_xfer, ch_kind;
    logic [31:0] ch_page;
    logic [63:0] ch_offset, ch_count;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    dma_regfile u0 (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    // Driver: pushes the expected byte, then presents the read.
    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
    endtask

    task automatic eng(input logic [1:0] c, input logic [15:0] o, input logic [15:0] n,
                       input logic rl);
        @(negedge clk);
        eng_ch = c; eng_offset = o; eng_count = n; eng_we = ~rl; eng_reload = rl;
        @(negedge clk);
        eng_we = 1'b0; eng_reload = 1'b0;
        #1;
    endtask

    // Monitor: pops one expected item per read cycle and compares.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (bus_rd) begin
                if (exp_q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
                end else begin
                    chk(tag_q.pop_front(), 64'(bus_rdata), 64'(exp_q.pop_front()));
                end
            end
        end
    end

    initial begin
        #(100000 * 10);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 mask after reset", 64'(ch_mask), 64'hF);
        chk("R1 modes after reset", 64'({ch_xfer, ch_kind, ch_dec, ch_autoinit}), 64'h0);
        chk("R1 counts after reset", ch_count, 64'h0);
        rd(8'h00, 8'h00, "R1 offset low after reset");
        rd(8'h00, 8'h00, "R1 offset high after reset");

        // R2 R4: channel 1 offset and count, low then high
        wr(8'h02, 8'h34); wr(8'h02, 8'h12);
        wr(8'h03, 8'h0F); wr(8'h03, 8'h00);
        chk("R2 R4 ch1 offset", 64'(ch_offset[31:16]), 64'h1234);
        chk("R2 R4 ch1 count", 64'(ch_count[31:16]), 64'h000F);
        chk("R4 ch0 untouched", 64'(ch_offset[15:0]), 64'h0);
        rd(8'h03, 8'h0F, "R3 count low read");
        rd(8'h03, 8'h00, "R3 count high read");
        rd(8'h02, 8'h34, "R3 offset low read");
        wr(8'h0C, 8'hFF);
        rd(8'h02, 8'h34, "R3 low after pointer clear");
        rd(8'h02, 8'h12, "R3 high after low");

        wr(8'h06, 8'hAA); wr(8'h06, 8'h55);
        chk("R4 ch3 offset", 64'(ch_offset[63:48]), 64'h55AA);

        // R5 pages
        wr(8'h87, 8'h1C); wr(8'h83, 8'h05); wr(8'h81, 8'h0A); wr(8'h82, 8'h0F);
        chk("R5 page map", 64'(ch_page), 64'h0F0A051C);
        rd(8'h87, 8'h00, "R5 page read is zero");
        rd(8'h0B, 8'h00, "R5 mode port read is zero");
        rd(8'h06, 8'hAA, "R5 pointer untouched by write-only ports");
        rd(8'h06, 8'h55, "R3 ch3 high");

        // R6 mode: block, decrement, autoinit, to memory, channel 2
        wr(8'h0B, 8'hB6);
        chk("R6 xfer", 64'(ch_xfer), 64'h20);
        chk("R6 dec and autoinit", 64'({ch_dec, ch_autoinit}), 64'h44);
        chk("R6 kind", 64'(ch_kind), 64'h10);

        // R7 single mask
        wr(8'h0A, 8'h01);
        chk("R7 unmask ch1", 64'(ch_mask), 64'hD);
        wr(8'h0A, 8'h05);
        chk("R7 mask ch1", 64'(ch_mask), 64'hF);
        wr(8'h0A, 8'h00);
        chk("R7 unmask ch0", 64'(ch_mask), 64'hE);

        // R9
        wr(8'h0E, 8'h00);
        chk("R9 master enable", 64'(ch_mask), 64'h0);
        wr(8'h0F, 8'hA5);
        chk("R9 master mask", 64'(ch_mask), 64'h5);

        // R12 R13
        wr(8'h09, 8'h07);
        chk("R12 request ch3", 64'(ch_req), 64'h8);
        wr(8'h08, 8'h42);
        chk("R13 command", 64'(cmd_out), 64'h42);

        // R10 engine update and reload
        eng(2'd1, 16'h1235, 16'h000E, 1'b0);
        chk("R10 eng offset", 64'(ch_offset[31:16]), 64'h1235);
        chk("R10 eng count", 64'(ch_count[31:16]), 64'h000E);
        rd(8'h03, 8'h0E, "R3 live count low");
        rd(8'h03, 8'h00, "R3 live count high");
        eng(2'd1, 16'h0000, 16'h0000, 1'b1);
        chk("R10 reload offset", 64'(ch_offset[31:16]), 64'h1234);
        chk("R10 reload count", 64'(ch_count[31:16]), 64'h000F);

        // R11 terminal count
        eng(2'd0, 16'h0000, 16'hFFFF, 1'b0);
        chk("R11 tc flag", 64'(ch_tc), 64'h1);
        rd(8'h08, 8'h81, "R11 status read");
        rd(8'h08, 8'h80, "R11 status cleared");
        rd(8'h01, 8'hFF, "R11 count reads FFFF");
        rd(8'h01, 8'hFF, "R11 count high FF");

        // R8 master reset
        wr(8'h00, 8'h77);
        wr(8'h0D, 8'h00);
        chk("R8 mask set", 64'(ch_mask), 64'hF);
        chk("R8 modes cleared", 64'({ch_xfer, ch_kind, ch_dec, ch_autoinit}), 64'h0);
        chk("R8 req tc cmd cleared", 64'({ch_req, ch_tc, cmd_out}), 64'h0);
        chk("R8 offsets kept", 64'(ch_offset[31:16]), 64'h1234);
        chk("R8 pages kept", 64'(ch_page), 64'h0F0A051C);
        rd(8'h00, 8'h77, "R8 pointer cleared");

        repeat (3) @(negedge clk);
        chk("R3 scoreboard drained", 64'(exp_q.size()), 64'h0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule